// File: doc/BRIEF.md
# In-Order Completion Buffer

This block lets work units finish out of order while their results leave in the order the work started. A requester asks for a token, and the buffer grants the index of the next free slot. The unit doing the work can finish at any later time. It writes its result back against that token, in any order relative to other outstanding tokens. The consumer side sees one result at a time: the oldest outstanding slot, offered only once its data has arrived.

Storage is a ring of `DEPTH` slots, each `DATA_W` bits wide with a valid flag. An issue pointer, a head pointer and an occupancy count track the ring. Both pointers wrap modulo `DEPTH`. Issuing a token clears the valid flag of the slot it names. A completion sets the flag. A read moves the head forward.

An occupancy state machine drives both handshakes. It has three states:
- `OCC_EMPTY`: no token is outstanding.
- `OCC_PARTIAL`: some tokens are outstanding, but fewer than `DEPTH`.
- `OCC_FULL`: all `DEPTH` tokens are outstanding.

It has four named transitions:
- `FIRST_ISSUE`: `OCC_EMPTY` to `OCC_PARTIAL`, on an issue.
- `FILL`: `OCC_PARTIAL` to `OCC_FULL`, on an issue without a read while `DEPTH-1` tokens are outstanding.
- `DRAIN`: `OCC_PARTIAL` to `OCC_EMPTY`, on a read without an issue while one token is outstanding.
- `RELEASE`: `OCC_FULL` to `OCC_PARTIAL`, on a read.

In every other case the state holds.

Top module: `inorder_cplbuf`

## Requirements
- R1: After reset no token is outstanding: `tok_gnt` is 1, `res_rdy` is 0 and `tok_id` is 0.
- R2: `tok_id` shows the slot the next issue will take. An issue (`tok_req` and `tok_gnt` both high at a clock edge) advances it by one. After `DEPTH-1` it wraps to 0.
- R3: `tok_gnt` is low exactly when `DEPTH` tokens are outstanding. While it is low, `tok_req` has no effect and `tok_id` holds.
- R4: A completion (`cpl_vld` high) writes `cpl_data` into the slot `cpl_tok` and marks that slot valid, whatever the order of completions. The bench sends completions only for outstanding tokens.
- R5: `res_rdy` is high only when at least one token is outstanding and the head slot is valid. A completion to the head slot raises `res_rdy` in the following cycle.
- R6: While `res_rdy` is high, `res_data` holds the head slot's data. A read (`res_take` and `res_rdy` high at an edge) advances the head by one, modulo `DEPTH`, and lowers the outstanding count by one.
- R7: Issuing a token clears that slot's valid flag. Data left in a reused slot from an earlier round is never offered as a result.
- R8: An issue and a read in the same cycle leave the outstanding count unchanged, and both pointers advance.
- R9: Under any completion order, results leave in exactly the order their tokens were issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_req | input | 1 | Request for a new token |
| tok_gnt | output | 1 | A token can be issued this cycle |
| tok_id | output | TOK_W | Index of the token the next issue takes |
| cpl_vld | input | 1 | Completion write strobe |
| cpl_tok | input | TOK_W | Token the completion belongs to |
| cpl_data | input | DATA_W | Completed result |
| res_rdy | output | 1 | Oldest result is available |
| res_data | output | DATA_W | Oldest result |
| res_take | input | 1 | Consumer accepts the oldest result |

## Verification
The main same-cycle clash is between a token issue and a result read. In that cycle the count must stay put while both pointers move. The bench provokes the clash in a directed run one slot short of full: it issues and reads together, then checks that `tok_gnt` stays high, and that exactly one further issue drops it. It also checks that a completion landing on the head slot makes `res_rdy` rise one cycle later. A random phase mixes issues, out-of-order completions and reads on most cycles, and compares every handshake output against a reference model of the ring.

// File: rtl/cplbuf_pkg.sv
package cplbuf_pkg;

    // Occupancy of the token ring.
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

    // Encoded request pair applied to the ring in one cycle.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_ISSUE = 2'b10,
        OP_BOTH  = 2'b11
    } ring_op_e;

endpackage

// File: rtl/cplbuf_ptr.sv
module cplbuf_ptr #(
    parameter int DEPTH = 8,
    parameter int TOK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [TOK_W-1:0] idx
);

    localparam logic [TOK_W-1:0] LAST = TOK_W'(DEPTH - 1);

    logic [TOK_W-1:0] idx_q;
    logic [TOK_W-1:0] idx_nxt;

    always_comb begin
        idx_nxt = idx_q;
        if (adv) begin
            if (idx_q == LAST) begin
                idx_nxt = '0;
            end else begin
                idx_nxt = idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_nxt;
        end
    end

    assign idx = idx_q;

endmodule

// File: rtl/cplbuf_store.sv
module cplbuf_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int TOK_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    // slot being handed out: flag cleared
    input  logic              clr_en,
    input  logic [TOK_W-1:0]  clr_idx,
    // completion: data written, flag set
    input  logic              wr_en,
    input  logic [TOK_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    // head slot view
    input  logic [TOK_W-1:0]  rd_idx,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0]  slot_vld;
    logic [DATA_W-1:0] slot_data [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic hit_clr;
        logic hit_wr;

        assign hit_clr = clr_en && (clr_idx == TOK_W'(s));
        assign hit_wr  = wr_en  && (wr_idx  == TOK_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[s] <= 1'b0;
            end else if (hit_clr) begin
                slot_vld[s] <= 1'b0;
            end else if (hit_wr) begin
                slot_vld[s] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_wr) begin
                slot_data[s] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_vld  = slot_vld[rd_idx];
        rd_data = slot_data[rd_idx];
    end

endmodule

// File: rtl/cplbuf_occ_fsm.sv
module cplbuf_occ_fsm
    import cplbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             read,
    output logic             can_issue,
    output logic             not_empty,
    output logic [CNT_W-1:0] occ_cnt
);

    localparam logic [CNT_W-1:0] CNT_ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_PREFULL = CNT_W'(DEPTH - 1);

    occ_state_e       state_q;
    occ_state_e       state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    ring_op_e         op;

    assign op = ring_op_e'({issue, read});

    // count datapath
    always_comb begin
        unique case (op)
            OP_ISSUE: cnt_nxt = cnt_q + 1'b1;
            OP_READ:  cnt_nxt = cnt_q - 1'b1;
            default:  cnt_nxt = cnt_q;
        endcase
    end

    // transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (issue) begin
                    state_nxt = OCC_PARTIAL;            // FIRST_ISSUE
                end
            end
            OCC_PARTIAL: begin
                if (op == OP_ISSUE && cnt_q == CNT_PREFULL) begin
                    state_nxt = OCC_FULL;               // FILL
                end else if (op == OP_READ && cnt_q == CNT_ONE) begin
                    state_nxt = OCC_EMPTY;              // DRAIN
                end
            end
            OCC_FULL: begin
                if (read) begin
                    state_nxt = OCC_PARTIAL;            // RELEASE
                end
            end
            default: state_nxt = OCC_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            OCC_EMPTY: begin
                can_issue = 1'b1;
                not_empty = 1'b0;
            end
            OCC_PARTIAL: begin
                can_issue = 1'b1;
                not_empty = 1'b1;
            end
            OCC_FULL: begin
                can_issue = 1'b0;
                not_empty = 1'b1;
            end
            default: begin
                can_issue = 1'b0;
                not_empty = 1'b0;
            end
        endcase
    end

    assign occ_cnt = cnt_q;

endmodule

// File: rtl/inorder_cplbuf.sv
module inorder_cplbuf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int TOK_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_req,
    output logic              tok_gnt,
    output logic [TOK_W-1:0]  tok_id,
    input  logic              cpl_vld,
    input  logic [TOK_W-1:0]  cpl_tok,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              res_rdy,
    output logic [DATA_W-1:0] res_data,
    input  logic              res_take
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             issue;
    logic             read;
    logic             can_issue;
    logic             not_empty;
    logic             head_vld;
    logic [TOK_W-1:0] in_idx;
    logic [TOK_W-1:0] head_idx;
    logic [CNT_W-1:0] occ_cnt;

    assign issue   = tok_req  && can_issue;
    assign read    = res_take && res_rdy;
    assign tok_gnt = can_issue;
    assign tok_id  = in_idx;
    assign res_rdy = not_empty && head_vld;

    cplbuf_ptr #(.DEPTH(DEPTH), .TOK_W(TOK_W)) u_in_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (issue),
        .idx   (in_idx)
    );

    cplbuf_ptr #(.DEPTH(DEPTH), .TOK_W(TOK_W)) u_head_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (read),
        .idx   (head_idx)
    );

    cplbuf_occ_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .read      (read),
        .can_issue (can_issue),
        .not_empty (not_empty),
        .occ_cnt   (occ_cnt)
    );

    cplbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TOK_W(TOK_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (issue),
        .clr_idx (in_idx),
        .wr_en   (cpl_vld),
        .wr_idx  (cpl_tok),
        .wr_data (cpl_data),
        .rd_idx  (head_idx),
        .rd_vld  (head_vld),
        .rd_data (res_data)
    );

endmodule

// File: rtl/cplbuf_chk.sv
module cplbuf_chk #(
    parameter int DEPTH = 8,
    parameter int TOK_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tok_req,
    input logic             tok_gnt,
    input logic [TOK_W-1:0] tok_id,
    input logic             cpl_vld,
    input logic [TOK_W-1:0] cpl_tok,
    input logic             res_take,
    input logic             res_rdy,
    input logic [TOK_W-1:0] head_idx,
    input logic [CNT_W-1:0] occ_cnt
);

    logic fire_iss;
    logic fire_rd;
    assign fire_iss = tok_req && tok_gnt;
    assign fire_rd  = res_take && res_rdy;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt <= CNT_W'(DEPTH)); // R3

    AST_GNT_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tok_gnt == (occ_cnt != CNT_W'(DEPTH))); // R3

    AST_TOK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_iss |=> $stable(tok_id)); // R3

    AST_TOK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_iss |=> tok_id == (($past(tok_id) == TOK_W'(DEPTH - 1)) ? '0 : $past(tok_id) + 1'b1)); // R2

    AST_RDY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        res_rdy |-> occ_cnt != '0); // R5

    AST_HEAD_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_vld && cpl_tok == head_idx && occ_cnt != '0 && !fire_rd) |=> res_rdy); // R4

    AST_BOTH_HOLD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_iss && fire_rd) |=> $stable(occ_cnt)); // R8

endmodule

bind inorder_cplbuf cplbuf_chk #(
    .DEPTH (DEPTH),
    .TOK_W (TOK_W),
    .CNT_W (CNT_W)
) u_cplbuf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_req  (tok_req),
    .tok_gnt  (tok_gnt),
    .tok_id   (tok_id),
    .cpl_vld  (cpl_vld),
    .cpl_tok  (cpl_tok),
    .res_take (res_take),
    .res_rdy  (res_rdy),
    .head_idx (head_idx),
    .occ_cnt  (occ_cnt)
);

// File: tb/test_inorder_cplbuf.sv
module test_inorder_cplbuf;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int DEPTH      = 8;
    localparam int TOK_W      = 3;
    localparam int WD_CYCLES  = 100000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              tok_req;
    logic              tok_gnt;
    logic [TOK_W-1:0]  tok_id;
    logic              cpl_vld;
    logic [TOK_W-1:0]  cpl_tok;
    logic [DATA_W-1:0] cpl_data;
    logic              res_rdy;
    logic [DATA_W-1:0] res_data;
    logic              res_take;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model
    int m_in, m_out, m_cnt;
    bit m_vld [DEPTH];
    int m_dat [DEPTH];
    int tok_seq [DEPTH];
    int iss_seq, rd_seq;
    int pend [DEPTH];
    int pcount;

    always #(CLK_PERIOD/2) clk = ~clk;

    inorder_cplbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TOK_W(TOK_W)) i_inorder_cplbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_req  (tok_req),
        .tok_gnt  (tok_gnt),
        .tok_id   (tok_id),
        .cpl_vld  (cpl_vld),
        .cpl_tok  (cpl_tok),
        .cpl_data (cpl_data),
        .res_rdy  (res_rdy),
        .res_data (res_data),
        .res_take (res_take)
    );

    function automatic int mk_data(int seq);
        return (seq * 40503 + 7) & 16'hFFFF;
    endfunction

    function automatic int wrap_inc(int v);
        return (v == DEPTH - 1) ? 0 : v + 1;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic void drop_pending(int tok);
        for (int k = 0; k < pcount; k++) begin
            if (pend[k] == tok) begin
                pend[k] = pend[pcount-1];
                pcount--;
                break;
            end
        end
    endfunction

    // one cycle: drive at negedge, check, apply at posedge, update model
    task automatic step(bit req, bit cpl, int tok, bit take);
        bit g, r;
        @(negedge clk);
        tok_req  = req;
        cpl_vld  = cpl;
        cpl_tok  = TOK_W'(tok);
        cpl_data = DATA_W'(cpl ? mk_data(tok_seq[tok]) : 0);
        res_take = take;
        #1;
        chk(tok_id == TOK_W'(m_in), "R2 tok_id", int'(tok_id), m_in);
        chk(tok_gnt == (m_cnt != DEPTH), "R3 tok_gnt", int'(tok_gnt), int'(m_cnt != DEPTH));
        chk(res_rdy == (m_cnt != 0 && m_vld[m_out]), "R5 res_rdy", int'(res_rdy),
            int'(m_cnt != 0 && m_vld[m_out]));
        if (res_rdy) begin
            chk(res_data == DATA_W'(m_dat[m_out]), "R6 res_data", int'(res_data), m_dat[m_out]);
            chk(res_data == DATA_W'(mk_data(rd_seq)), "R9 order", int'(res_data), mk_data(rd_seq));
        end
        g = tok_gnt;
        r = res_rdy;
        @(posedge clk);
        #1;
        if (req && g) begin
            m_vld[m_in]   = 1'b0;
            tok_seq[m_in] = iss_seq;
            iss_seq++;
            pend[pcount]  = m_in;
            pcount++;
            m_in = wrap_inc(m_in);
        end
        if (cpl) begin
            m_vld[tok] = 1'b1;
            m_dat[tok] = mk_data(tok_seq[tok]);
            drop_pending(tok);
        end
        if (take && r) begin
            m_out = wrap_inc(m_out);
            rd_seq++;
        end
        m_cnt = m_cnt + int'(req && g) - int'(take && r);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", n_tests, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; tok_req = 0; cpl_vld = 0; cpl_tok = '0; cpl_data = '0; res_take = 0;
        m_in = 0; m_out = 0; m_cnt = 0; iss_seq = 0; rd_seq = 0; pcount = 0;
        for (int k = 0; k < DEPTH; k++) begin
            m_vld[k] = 0; m_dat[k] = 0; tok_seq[k] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(tok_gnt == 1'b1, "R1 gnt", int'(tok_gnt), 1);
        chk(res_rdy == 1'b0, "R1 rdy", int'(res_rdy), 0);
        chk(tok_id == '0, "R1 tok_id", int'(tok_id), 0);

        // R4 R5: three tokens, completed out of order 2, 0, 1
        for (int k = 0; k < 3; k++) step(1, 0, 0, 0);
        step(0, 1, 2, 1);
        chk(res_rdy == 1'b0, "R5 head not ready", int'(res_rdy), 0);
        step(0, 1, 0, 0);
        chk(res_rdy == 1'b1, "R4 head ready", int'(res_rdy), 1);
        step(0, 1, 1, 1);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        chk(res_rdy == 1'b0, "R6 drained", int'(res_rdy), 0);

        // R3 fill to full; extra request ignored
        for (int k = 0; k < DEPTH; k++) step(1, 0, 0, 0);
        chk(tok_gnt == 1'b0, "R3 full", int'(tok_gnt), 0);
        step(1, 0, 0, 0);
        chk(tok_id == TOK_W'(m_in), "R3 id held", int'(tok_id), m_in);

        // R7: read the head, reuse its slot, then drain everything else
        begin
            int h;
            int reused;
            h = m_out;
            step(0, 1, h, 0);
            step(0, 0, 0, 1);
            reused = m_in;
            step(1, 0, 0, 0);
            for (int k = 1; k < DEPTH; k++) begin
                step(0, 1, (h + k) % DEPTH, 1);
            end
            while (m_out != reused) step(0, 0, 0, 1);
            chk(res_rdy == 1'b0, "R7 stale slot", int'(res_rdy), 0);
            step(0, 1, reused, 0);
            step(0, 0, 0, 1);
        end

        // R8: one short of full, issue and read together
        for (int k = 0; k < DEPTH - 1; k++) step(1, 0, 0, 0);
        step(0, 1, m_out, 0);
        step(1, 0, 0, 1);
        chk(tok_gnt == 1'b1, "R8 count held", int'(tok_gnt), 1);
        step(1, 0, 0, 0);
        chk(tok_gnt == 1'b0, "R8 one more fills", int'(tok_gnt), 0);
        while (pcount > 0) step(0, 1, pend[0], 1);
        while (m_cnt > 0) step(0, 0, 0, 1);

        // R9 random phase
        for (int c = 0; c < 3000; c++) begin
            bit dc;
            int t;
            dc = (pcount > 0) && ($urandom % 2 == 1);
            t  = dc ? pend[$urandom % pcount] : 0;
            step($urandom % 3 != 0, dc, t, $urandom % 4 != 0);
        end
        while (pcount > 0) step(0, 1, pend[$urandom % pcount], 1);
        while (m_cnt > 0) step(0, 0, 0, 1);
        chk(rd_seq == iss_seq, "R9 all released", rd_seq, iss_seq);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule